// File: doc/BRIEF.md
# On-Screen Display Frame Control with Page Clear

This block holds the 8-bit frame control word of an on-screen display overlay. From that word it derives a master display enable and two window enables. Each window enable is gated by the master enable. The block also decides, without a clock, whether a palette entry counts as see-through.

A self-clearing sweep engine sits next to the register. Once the clear bit is set, the engine writes zero into every page RAM location, one address per clock, in ascending order. It then drops the clear bit by itself. The clear bit comes out of reset set, so the page memory is always blanked after power-up without any software action.

Software writes the whole word at once and reads it back live, so the clear bit can be polled. The page RAM port is only a write port, and only the sweep engine drives it.

Top module: `osd_frame_ctrl`

## Requirements
- R1: After reset the control word reads 0x08 and `clr_busy` is 1.
- R2: `osd_en` equals bit 0 of the control word.
- R3: `win1_en` is 1 only when bits 1 and 0 of the control word are both 1.
- R4: `win2_en` is 1 only when bits 2 and 0 of the control word are both 1.
- R5: Writing a word with bit 3 set starts a sweep. In the cycle after the write, `pram_we` is 1 with `pram_addr` 0. The address then rises by one each cycle up to 2^PRAM_AW-1, and `pram_wdata` is always 0. `pram_we` is 0 whenever no sweep runs.
- R6: Exactly 2^PRAM_AW cycles after a sweep starts, bit 3 reads 0 and `clr_busy` is 0.
- R7: After reset is released, a full sweep starting at address 0 runs with no register write.
- R8: A write during a sweep leaves bit 3 at 1 whatever value is written to bit 3, and it does not lengthen or shorten the sweep. The other seven bits take the written value.
- R9: With bit 6 at 0, `pal_transparent` is 1 when `pal_val` is 0x00 and `pal_idx` is 0 to 7.
- R10: With bit 6 at 1, `pal_transparent` is 0 for every index and value.
- R11: `pal_transparent` is 0 whenever `pal_idx` is 8 or above, and whenever `pal_val` is not 0x00.
- R12: Bits 4, 5 and 7 read back as written and affect no output.
- R13: `reg_rd_data` shows the live control word, so bit 3 reads 1 throughout a sweep, and `clr_busy` equals that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_wr_data | input | 8 | Value to write |
| reg_rd_data | output | 8 | Live control word |
| osd_en | output | 1 | Master display enable |
| win1_en | output | 1 | Window 1 enable |
| win2_en | output | 1 | Window 2 enable |
| clr_busy | output | 1 | Page sweep in progress |
| pram_we | output | 1 | Page RAM write enable |
| pram_addr | output | PRAM_AW | Page RAM write address |
| pram_wdata | output | PRAM_DW | Page RAM write data (zero) |
| pal_idx | input | PAL_IW | Palette index under lookup |
| pal_val | input | PAL_VW | Palette value read at that index |
| pal_transparent | output | 1 | Entry is treated as see-through |

## Verification
The assertions assume that reset is held for at least one clock edge, so the sweep counter starts from zero. They also assume that the write strobe and the palette inputs are known, not X, at every sampled edge. The bench drives every input to a defined value from time zero. It changes the inputs only on falling edges and holds reset over several edges before releasing it. Palette inputs change only while no register write is pending, so each transparency check sees a settled control word.

// File: rtl/osdfc_pkg.sv
package osdfc_pkg;

    localparam int CTRL_W = 8;

    typedef struct packed {
        logic       spare7;
        logic       transp_dis;
        logic [1:0] spare54;
        logic       clr;
        logic       win2;
        logic       win1;
        logic       master;
    } frame_ctrl_t;

    typedef struct packed {
        logic osd;
        logic w1;
        logic w2;
    } win_en_t;

    localparam frame_ctrl_t CTRL_RST = frame_ctrl_t'(8'h08);

    function automatic win_en_t decode_windows(input frame_ctrl_t c);
        win_en_t e;
        e.osd = c.master;
        e.w1  = c.master & c.win1;
        e.w2  = c.master & c.win2;
        return e;
    endfunction

endpackage

// File: rtl/osdfc_clear_eng.sv
module osdfc_clear_eng #(
    parameter int AW = 8,
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    output logic          we,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic          done
);
    localparam logic [AW-1:0] LAST = '1;

    logic [AW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= done ? '0 : cnt + 1'b1;
        end
    end

    always_comb begin
        we    = run;
        addr  = cnt;
        wdata = '0;
        done  = run && (cnt == LAST);
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (we && $past(we) && !$past(rst) && $past(addr) != LAST) |-> addr == $past(addr) + 1'b1); // R5

    AST_SWEEP_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(we) |-> addr == '0); // R5

endmodule

// File: rtl/osdfc_ctrl_reg.sv
module osdfc_ctrl_reg
    import osdfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              clr_done,
    output frame_ctrl_t       ctrl
);
    frame_ctrl_t nxt;

    always_comb begin
        nxt = ctrl;
        if (wr_en) nxt = frame_ctrl_t'(wr_data);
        if (ctrl.clr) nxt.clr = !clr_done;
        else          nxt.clr = wr_en & wr_data[3];
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl <= CTRL_RST;
        else     ctrl <= nxt;
    end

    AST_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr_done |=> !ctrl.clr); // R6

    AST_CLR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ctrl.clr && !clr_done) |=> ctrl.clr); // R8

    AST_SPARE_STORE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ({ctrl.spare7, ctrl.spare54} == {$past(wr_data[7]), $past(wr_data[5:4])})); // R12

endmodule

// File: rtl/osdfc_transp.sv
module osdfc_transp #(
    parameter int IW  = 4,
    parameter int VW  = 8,
    parameter int LOW = 8
) (
    input  logic          transp_dis,
    input  logic [IW-1:0] idx,
    input  logic [VW-1:0] val,
    output logic          transparent
);
    localparam logic [IW-1:0] LOW_LIM = IW'(LOW);

    always_comb begin
        transparent = !transp_dis && (idx < LOW_LIM) && (val == '0);
    end

endmodule

// File: rtl/osd_frame_ctrl.sv
module osd_frame_ctrl
    import osdfc_pkg::*;
#(
    parameter int PRAM_AW = 8,
    parameter int PRAM_DW = 12,
    parameter int PAL_IW  = 4,
    parameter int PAL_VW  = 8,
    parameter int PAL_LOW = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr_en,
    input  logic [CTRL_W-1:0]  reg_wr_data,
    output logic [CTRL_W-1:0]  reg_rd_data,
    output logic               osd_en,
    output logic               win1_en,
    output logic               win2_en,
    output logic               clr_busy,
    output logic               pram_we,
    output logic [PRAM_AW-1:0] pram_addr,
    output logic [PRAM_DW-1:0] pram_wdata,
    input  logic [PAL_IW-1:0]  pal_idx,
    input  logic [PAL_VW-1:0]  pal_val,
    output logic               pal_transparent
);
    localparam logic [PAL_IW-1:0] LOW_LIM = PAL_IW'(PAL_LOW);

    frame_ctrl_t ctrl;
    win_en_t     wins;
    logic        sweep_done;

    osdfc_ctrl_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr_en),
        .wr_data  (reg_wr_data),
        .clr_done (sweep_done),
        .ctrl     (ctrl)
    );

    osdfc_clear_eng #(.AW(PRAM_AW), .DW(PRAM_DW)) u_eng (
        .clk   (clk),
        .rst   (rst),
        .run   (ctrl.clr),
        .we    (pram_we),
        .addr  (pram_addr),
        .wdata (pram_wdata),
        .done  (sweep_done)
    );

    osdfc_transp #(.IW(PAL_IW), .VW(PAL_VW), .LOW(PAL_LOW)) u_tr (
        .transp_dis  (ctrl.transp_dis),
        .idx         (pal_idx),
        .val         (pal_val),
        .transparent (pal_transparent)
    );

    always_comb begin
        wins        = decode_windows(ctrl);
        osd_en      = wins.osd;
        win1_en     = wins.w1;
        win2_en     = wins.w2;
        clr_busy    = ctrl.clr;
        reg_rd_data = ctrl;
    end

    AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        pram_we |-> reg_rd_data[3]); // R5

    AST_WIN_GATED: assert property (@(posedge clk) disable iff (rst)
        (win1_en || win2_en) |-> osd_en); // R3

    AST_TD_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        reg_rd_data[6] |-> !pal_transparent); // R10

    AST_NO_HIGH_TRANSP: assert property (@(posedge clk) disable iff (rst)
        (pal_idx >= LOW_LIM || pal_val != '0) |-> !pal_transparent); // R11

endmodule

// File: tb/osd_frame_ctrl_tb_top.sv
`timescale 1ns/1ps
module osd_frame_ctrl_tb_top;
    localparam int AW    = 8;
    localparam int DW    = 12;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr_en = 1'b0;
    logic [7:0]    reg_wr_data = '0;
    logic [7:0]    reg_rd_data;
    logic          osd_en, win1_en, win2_en, clr_busy, pram_we, pal_transparent;
    logic [AW-1:0] pram_addr;
    logic [DW-1:0] pram_wdata;
    logic [3:0]    pal_idx = '0;
    logic [7:0]    pal_val = 8'hFF;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    osd_frame_ctrl #(.PRAM_AW(AW), .PRAM_DW(DW)) dut_i (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .osd_en(osd_en), .win1_en(win1_en), .win2_en(win2_en),
        .clr_busy(clr_busy), .pram_we(pram_we), .pram_addr(pram_addr), .pram_wdata(pram_wdata),
        .pal_idx(pal_idx), .pal_val(pal_val), .pal_transparent(pal_transparent)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        reg_wr_en   = 1'b1;
        reg_wr_data = v;
        @(negedge clk);
        reg_wr_en   = 1'b0;
    endtask

    // Called at the falling edge where address 0 should be showing.
    task automatic sweep(input string req);
        int bad = 0;
        for (int k = 0; k < DEPTH; k++) begin
            // R13: bit 3 and busy stay high through the sweep
            if (!(pram_we === 1'b1 && pram_addr === AW'(k) && pram_wdata === '0 &&
                  clr_busy === 1'b1 && reg_rd_data[3] === 1'b1)) bad++;
            @(negedge clk);
        end
        chk({req, " sweep mismatches"}, bad, 0);
        chk("R6 busy low after sweep", clr_busy, 0);
        chk("R6 bit3 low after sweep", reg_rd_data[3], 0);
        chk("R5 no write when idle", pram_we, 0);
    endtask

    task automatic t_powerup();
        repeat (3) @(negedge clk);
        chk("R1 reset word", reg_rd_data, 8'h08);
        chk("R1 busy in reset", clr_busy, 1);
        rst = 1'b0;
        sweep("R7");
    endtask

    task automatic t_write_sweep();
        wr(8'h08);
        sweep("R5");
    endtask

    task automatic t_write_during();
        int c = 0;
        wr(8'h08);
        repeat (10) @(negedge clk);
        wr(8'hB0);
        chk("R8 bit3 kept, others taken", reg_rd_data, 8'hB8);
        chk("R13 busy during sweep", clr_busy, 1);
        while (clr_busy === 1'b1 && c < 2 * DEPTH) begin
            @(negedge clk);
            c++;
        end
        chk("R8 sweep length unchanged", c, DEPTH - 11);
        chk("R6 word after sweep", reg_rd_data, 8'hB0);
    endtask

    task automatic t_spare();
        wr(8'hA0);
        chk("R12 spare bits read", reg_rd_data, 8'hA0);
        chk("R12 no enables", {osd_en, win1_en, win2_en, clr_busy}, 0);
        wr(8'h30);
        chk("R12 spare bits read 2", reg_rd_data, 8'h30);
        chk("R12 no sweep", pram_we, 0);
    endtask

    task automatic t_enables();
        for (int v = 0; v < 8; v++) begin
            wr(8'(v));
            chk("R2 master", osd_en, v[0]);
            chk("R3 window1", win1_en, v[0] & v[1]);
            chk("R4 window2", win2_en, v[0] & v[2]);
        end
    endtask

    task automatic t_transp();
        wr(8'h01);
        pal_idx = 4'd3; pal_val = 8'h00; #1;
        chk("R9 idx3 black", pal_transparent, 1);
        pal_idx = 4'd0; #1;
        chk("R9 idx0 black", pal_transparent, 1);
        pal_idx = 4'd7; #1;
        chk("R9 idx7 black", pal_transparent, 1);
        pal_val = 8'h01; #1;
        chk("R11 idx7 nonblack", pal_transparent, 0);
        pal_idx = 4'd8; pal_val = 8'h00; #1;
        chk("R11 idx8 black", pal_transparent, 0);
        pal_idx = 4'd15; #1;
        chk("R11 idx15 black", pal_transparent, 0);
        @(negedge clk);
        wr(8'h41);
        pal_idx = 4'd0; pal_val = 8'h00; #1;
        chk("R10 disabled idx0", pal_transparent, 0);
        pal_idx = 4'd5; #1;
        chk("R10 disabled idx5", pal_transparent, 0);
        @(negedge clk);
    endtask

    initial begin
        t_powerup();
        t_write_sweep();
        t_write_during();
        t_spare();
        t_enables();
        t_transp();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule